// File: doc/BRIEF.md
# Multi-Mode Comma Character Framer

This block takes a recovered serial bit stream, one bit per clock, and finds where each 10-bit character begins. It looks for a framing (comma) character in a sliding window and produces aligned characters together with a one-cycle character strobe. The character clock is modelled as that strobe: an enable taken from a bit counter that wraps every ten bits.

Three alignment policies can be selected. The fast policy realigns on a single comma. It does this by holding the bit counter for a few cycles, which stretches the character period. The two robust policies leave the character clock phase alone. They move the data window relative to the existing strobe, and only after repeated commas on one and the same boundary: two commas within a 50-bit span, or four back to back.

Any change of boundary raises a one-cycle flag. A framing enable freezes the current boundary, whatever the stream contains.

Top module: `comma_framer`

## Requirements
- R1: A comma is a window whose seven earliest-received bits are 0011111 or 1100000, in arrival order. The first-received bit of each character appears on `char_out[9]`.
- R2: `char_stb` is a one-cycle pulse that accompanies each new `char_out`. Without any realignment it recurs exactly every 10 clocks.
- R3: With `mode` = 0 (single detection) and framing enabled, one comma that is off the current boundary moves the character clock, so that a later comma on the same boundary is delivered whole on `char_out`.
- R4: While realigning in `mode` 0, no character period exceeds 12 clocks, which is two bit periods of stretch at most.
- R5: With `mode` = 1, the boundary moves only when two commas end on the same offset no more than 40 bits apart, so that both fit in a 50-bit span. Commas spaced further apart change nothing.
- R6: With `mode` = 1, a comma on a different offset discards the earlier sighting, so a pair that straddles two offsets causes no realignment.
- R7: With `mode` = 2 or 3, the boundary moves only after four commas arrive as consecutive characters on one offset. Three in a row change nothing.
- R8: In modes 1 to 3, the character strobe period stays exactly 10 clocks at all times. Realignment shifts the data window instead of the strobe.
- R9: With `frame_en` low, no comma changes the boundary and `realign` stays low.
- R10: `realign` pulses for exactly one cycle each time the boundary actually changes. A comma that is already on the boundary produces no pulse.
- R11: While `rst_n` is low, `char_stb`, `realign` and `char_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Recovered serial bit, one per clock |
| frame_en | input | 1 | High allows boundary updates; low freezes the boundary |
| mode | input | 2 | 0 single detection, 1 pair within span, 2 or 3 four consecutive |
| char_out | output | CHAR_W | Aligned character, first-received bit in the MSB |
| char_stb | output | 1 | One-cycle strobe marking a new character |
| realign | output | 1 | One-cycle pulse when the boundary changes |

## Verification
The stream is built from an alternating filler that can never hold a comma. Commas of either polarity are placed into it with bit-level slips of known size, so every detection is intentional.

- **Single-detection mode:** lone slipped commas tell the single-detection path apart from the others, and show that the strobe period stretches.
- **Pair mode:** commas 70 bits apart, commas on two offsets, and commas 20 bits apart separate the span rule from the same-offset rule.
- **Strict mode:** runs of three and of four consecutive commas probe the consecutive-count threshold.
- **Freeze:** a run with the enable low shows that the boundary is held.

In each case, a comma sent afterwards either does or does not emerge whole on `char_out`. That shows where the boundary ended up.

// File: rtl/comma_framer_pkg.sv
package comma_framer_pkg;

  localparam int CF_CHAR_W  = 10;
  localparam int CF_COMMA_W = 7;
  localparam logic [CF_COMMA_W-1:0] CF_COMMA_PAT = 7'b0011111;

  typedef enum logic [1:0] {
    FM_SINGLE   = 2'd0,
    FM_PAIR     = 2'd1,
    FM_QUAD     = 2'd2,
    FM_QUAD_ALT = 2'd3
  } frame_mode_e;

  // either polarity of the comma in the earliest-received bits
  function automatic logic is_comma(input logic [CF_COMMA_W-1:0] lead);
    return (lead == CF_COMMA_PAT) || (lead == ~CF_COMMA_PAT);
  endfunction

  // counter holds needed so the strobe lands on a comma seen at counter value phase
  function automatic int slip_for_phase(input int phase, input int w);
    return (phase + 1) % w;
  endfunction

  // data-window offset at strobe time for a comma completed at counter value phase
  function automatic int ofs_for_phase(input int phase, input int w);
    return w - 1 - phase;
  endfunction

endpackage

// File: rtl/cf_shift_detect.sv
module cf_shift_detect
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W = CF_CHAR_W,
  localparam int SR_W = 2 * CHAR_W - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_in,
  output logic [SR_W-1:0] sr,
  output logic            comma_hit
);

  // sr[0] holds the newest bit; sr[CHAR_W-1] is the oldest bit of the last character
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[SR_W-2:0], bit_in};
  end

  assign comma_hit = is_comma(sr[CHAR_W-1 -: CF_COMMA_W]);

  // the two comma patterns cannot overlap themselves at a one-bit shift
  AST_COMMA_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    comma_hit |=> !comma_hit);  // R1

endmodule

// File: rtl/cf_char_clock.sv
module cf_char_clock
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W      = CF_CHAR_W,
  parameter int MAX_STRETCH = 2,
  localparam int CNT_W  = $clog2(CHAR_W),
  localparam int HELD_W = $clog2(MAX_STRETCH + 1),
  localparam int PCNT_W = $clog2(CHAR_W + MAX_STRETCH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_en,
  input  logic             det_fire,
  output logic [CNT_W-1:0] cnt,
  output logic             char_tick,
  output logic             realign_single
);

  logic [CNT_W-1:0]  slip;
  logic [CNT_W-1:0]  slip_new;
  logic [HELD_W-1:0] held;
  logic              hold;

  assign slip_new       = CNT_W'(slip_for_phase(int'(cnt), CHAR_W));
  assign char_tick      = (cnt == CNT_W'(CHAR_W - 1));
  assign realign_single = single_en && det_fire && (slip_new != '0);
  // stretch only at the start of a character, bounded per character
  assign hold = single_en && (slip != '0) && (cnt == '0) &&
                (held < HELD_W'(MAX_STRETCH)) && !det_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= '0;
      slip <= '0;
    end else begin
      if (hold) begin
        held <= held + HELD_W'(1);
      end else begin
        held <= '0;
        cnt  <= char_tick ? '0 : cnt + CNT_W'(1);
      end
      if (!single_en)    slip <= '0;
      else if (det_fire) slip <= slip_new;
      else if (hold)     slip <= slip - CNT_W'(1);
    end
  end

  // cycles since the previous character tick
  logic [PCNT_W-1:0] pcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pcnt <= '0;
    else if (char_tick)                  pcnt <= '0;
    else if (pcnt != {PCNT_W{1'b1}})     pcnt <= pcnt + PCNT_W'(1);
  end

  AST_STRETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    char_tick |-> (pcnt <= PCNT_W'(CHAR_W + MAX_STRETCH - 1)));  // R4

  AST_NO_PHASE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    !single_en |=> (cnt != $past(cnt)));  // R8

endmodule

// File: rtl/cf_multi_policy.sv
module cf_multi_policy
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W    = CF_CHAR_W,
  parameter int PAIR_SPAN = 50,
  parameter int QUAD_N    = 4,
  localparam int CNT_W    = $clog2(CHAR_W),
  localparam int AGE_W    = $clog2(PAIR_SPAN) + 1,
  localparam int RUN_W    = $clog2(QUAD_N + 1),
  localparam int PAIR_LIM = PAIR_SPAN - CHAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_fire,
  input  frame_mode_e      mode,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] ofs,
  output logic             realign_multi
);

  logic [CNT_W-1:0] dc;
  logic [CNT_W-1:0] cand;
  logic [AGE_W-1:0] age;
  logic [RUN_W-1:0] run;
  logic             have;
  logic             pair_act, quad_act, pair_hit, quad_chain, quad_hit, hit;

  assign dc         = CNT_W'(ofs_for_phase(int'(cnt), CHAR_W));
  assign pair_act   = det_fire && (mode == FM_PAIR);
  assign quad_act   = det_fire && ((mode == FM_QUAD) || (mode == FM_QUAD_ALT));
  assign pair_hit   = pair_act && have && (cand == dc) && (age <= AGE_W'(PAIR_LIM));
  assign quad_chain = quad_act && (run != '0) && (cand == dc) && (age == AGE_W'(CHAR_W));
  assign quad_hit   = quad_chain && (run == RUN_W'(QUAD_N - 1));
  assign hit        = pair_hit || quad_hit;
  assign realign_multi = hit && (dc != ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs  <= '0;
      cand <= '0;
      age  <= '1;
      run  <= '0;
      have <= 1'b0;
    end else begin
      if (det_fire)            age <= AGE_W'(1);
      else if (age != '1)      age <= age + AGE_W'(1);

      if (pair_hit)                          have <= 1'b0;
      else if (pair_act)                     have <= 1'b1;
      else if (age > AGE_W'(PAIR_LIM))       have <= 1'b0;

      if ((pair_act && !pair_hit) || (quad_act && !quad_chain)) cand <= dc;

      if (quad_hit)                          run <= '0;
      else if (quad_chain)                   run <= run + RUN_W'(1);
      else if (quad_act)                     run <= RUN_W'(1);
      else if (age > AGE_W'(CHAR_W))         run <= '0;

      if (hit) ofs <= dc;
    end
  end

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ofs < CNT_W'(CHAR_W));  // R5

  AST_OFS_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !det_fire |=> $stable(ofs));  // R9

endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W      = CF_CHAR_W,
  parameter int PAIR_SPAN   = 50,
  parameter int QUAD_N      = 4,
  parameter int MAX_STRETCH = 2,
  localparam int CNT_W = $clog2(CHAR_W),
  localparam int SR_W  = 2 * CHAR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              frame_en,
  input  logic [1:0]        mode,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_stb,
  output logic              realign
);

  frame_mode_e      mode_e;
  logic [SR_W-1:0]  sr;
  logic [SR_W-1:0]  sr_sh;
  logic             comma_hit, det_fire, single_en;
  logic [CNT_W-1:0] cnt, ofs, ofs_sel;
  logic             char_tick, realign_single, realign_multi;

  assign mode_e    = frame_mode_e'(mode);
  assign det_fire  = comma_hit && frame_en;
  assign single_en = frame_en && (mode_e == FM_SINGLE);
  assign ofs_sel   = (mode_e == FM_SINGLE) ? '0 : ofs;
  assign sr_sh     = sr >> ofs_sel;

  cf_shift_detect #(.CHAR_W(CHAR_W)) u_det (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .sr(sr), .comma_hit(comma_hit)
  );

  cf_char_clock #(.CHAR_W(CHAR_W), .MAX_STRETCH(MAX_STRETCH)) u_clk (
    .clk(clk), .rst_n(rst_n), .single_en(single_en), .det_fire(det_fire),
    .cnt(cnt), .char_tick(char_tick), .realign_single(realign_single)
  );

  cf_multi_policy #(.CHAR_W(CHAR_W), .PAIR_SPAN(PAIR_SPAN), .QUAD_N(QUAD_N)) u_pol (
    .clk(clk), .rst_n(rst_n), .det_fire(det_fire), .mode(mode_e), .cnt(cnt),
    .ofs(ofs), .realign_multi(realign_multi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_out <= '0;
      char_stb <= 1'b0;
      realign  <= 1'b0;
    end else begin
      char_stb <= char_tick;
      realign  <= realign_single || realign_multi;
      if (char_tick) char_out <= sr_sh[CHAR_W-1:0];
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    char_stb |=> !char_stb);  // R2

  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> !realign);  // R9

  AST_REALIGN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !realign);  // R10

endmodule

// File: tb/sim_comma_framer.sv
module sim_comma_framer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_in;
  logic       frame_en;
  logic [1:0] mode;
  logic [9:0] char_out;
  logic       char_stb;
  logic       realign;

  localparam logic [9:0] COMMA_P = 10'b0011111010;
  localparam logic [9:0] COMMA_N = 10'b1100000101;
  localparam logic [9:0] FILLER  = 10'b1010101010;

  always #4ns clk = ~clk;

  comma_framer u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .frame_en(frame_en), .mode(mode),
    .char_out(char_out), .char_stb(char_stb), .realign(realign)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: bit history list and integer bookkeeping
  int hist[$];
  int m_cnt, m_slip, m_held, m_ofs, m_age, m_have, m_cand, m_run;
  bit m_stb, m_re;
  logic [9:0] m_out;

  always @(posedge clk) begin : ref_model
    int c, dc, s, v, ox, md;
    bit det, hold;
    if (!rst_n) begin
      m_cnt = 0; m_slip = 0; m_held = 0; m_ofs = 0; m_age = 1000;
      m_have = 0; m_cand = 0; m_run = 0; m_stb = 0; m_re = 0; m_out = '0;
      hist.delete();
      for (int i = 0; i < 19; i++) hist.push_back(0);
    end else begin
      md = int'(mode);
      c = m_cnt;
      dc = 9 - c;
      v = 0;
      for (int i = 9; i >= 3; i--) v = v * 2 + hist[i];
      det = frame_en && (v == 31 || v == 96);
      hold = (md == 0) && frame_en && (m_slip > 0) && (c == 0) && (m_held < 2) && !det;
      m_stb = (c == 9);
      if (m_stb) begin
        ox = (md == 0) ? 0 : m_ofs;
        v = 0;
        for (int i = ox + 9; i >= ox; i--) v = v * 2 + hist[i];
        m_out = 10'(v);
      end
      m_re = 0;
      if (md != 0 || !frame_en) m_slip = 0;
      else if (det) begin
        s = (c + 1) % 10;
        m_slip = s;
        m_re = (s != 0);
      end else if (hold) m_slip--;
      if (det && md == 1) begin
        if (m_have != 0 && m_cand == dc && m_age <= 40) begin
          if (dc != m_ofs) begin m_ofs = dc; m_re = 1; end
          m_have = 0;
        end else begin
          m_have = 1; m_cand = dc;
        end
      end
      if (det && md >= 2) begin
        if (m_run > 0 && m_cand == dc && m_age == 10) begin
          m_run++;
          if (m_run == 4) begin
            m_run = 0;
            if (dc != m_ofs) begin m_ofs = dc; m_re = 1; end
          end
        end else begin
          m_run = 1; m_cand = dc;
        end
      end
      if (det) m_age = 1;
      else if (m_age < 1000) m_age++;
      if (hold) m_held++;
      else begin m_held = 0; m_cnt = (c + 1) % 10; end
      hist.push_front(int'(bit_in));
      void'(hist.pop_back());
    end
  end

  // per-segment observations
  int re_cnt, pmin, pmax, cyc;
  bit saw_p, saw_n, have_prev;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R2 char_stb", int'(char_stb), int'(m_stb));
      chk("R10 realign", int'(realign), int'(m_re));
      if (m_stb) chk("R1 char_out", int'(char_out), int'(m_out));
      if (realign) re_cnt++;
      if (char_stb && char_out == COMMA_P) saw_p = 1;
      if (char_stb && char_out == COMMA_N) saw_n = 1;
      cyc++;
      if (char_stb) begin
        if (have_prev) begin
          if (cyc < pmin) pmin = cyc;
          if (cyc > pmax) pmax = cyc;
        end
        have_prev = 1;
        cyc = 0;
      end
    end
  end

  task automatic seg_start();
    re_cnt = 0; saw_p = 0; saw_n = 0; pmin = 1000; pmax = 0; have_prev = 0; cyc = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
  endtask

  task automatic send_char(input logic [9:0] ch);
    for (int i = 9; i >= 0; i--) send_bit(ch[i]);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) send_char(FILLER);
  endtask

  task automatic slip_bits(input int n);
    for (int i = 0; i < n; i++) send_bit((i % 2) == 0);
  endtask

  task automatic commas(input int n);
    for (int i = 0; i < n; i++) send_char(COMMA_P);
  endtask

  initial begin
    rst_n = 1'b0; bit_in = 1'b0; frame_en = 1'b1; mode = 2'd0;
    seg_start();
    repeat (3) @(negedge clk);
    chk("R11 reset char_stb", int'(char_stb), 0);
    chk("R11 reset realign", int'(realign), 0);
    chk("R11 reset char_out", int'(char_out), 0);
    rst_n = 1'b1;

    // single detection: lock, then a 4-bit slip
    fill(3); commas(1); fill(6);
    seg_start(); commas(1); fill(6);
    chk("R3 aligned comma framed", int'(saw_p), 1);
    seg_start(); slip_bits(4); commas(1); fill(6); commas(1); fill(6);
    chk("R3 comma framed after slip", int'(saw_p), 1);
    chk("R10 one pulse, none for aligned comma", re_cnt, 1);
    chk("R4 stretch at most two bits", int'(pmax <= 12), 1);
    chk("R4 period was stretched", int'(pmax > 10), 1);
    seg_start(); slip_bits(3); send_char(COMMA_N); fill(6); send_char(COMMA_N); fill(6);
    chk("R1 inverted comma framed", int'(saw_n), 1);
    chk("R10 inverted comma pulse count", re_cnt, 1);

    // pair mode
    mode = 2'd1;
    seg_start(); commas(1); fill(1); commas(1); fill(2); commas(1); fill(6);
    chk("R5 pair keeps aligned framing", int'(saw_p), 1);
    chk("R8 period fixed in pair mode (min)", pmin, 10);
    chk("R8 period fixed in pair mode (max)", pmax, 10);
    seg_start(); slip_bits(3); commas(1); fill(6); commas(1); fill(6);
    chk("R5 commas 70 bits apart no realign", re_cnt, 0);
    chk("R5 commas 70 bits apart not framed", int'(saw_p), 0);
    seg_start(); commas(1); fill(1); slip_bits(3); commas(1); fill(6);
    chk("R6 different offsets no realign", re_cnt, 0);
    chk("R6 different offsets not framed", int'(saw_p), 0);
    seg_start(); commas(1); fill(1); commas(1); fill(2); commas(1); fill(6);
    chk("R5 close pair realigns once", re_cnt, 1);
    chk("R5 close pair framed", int'(saw_p), 1);
    chk("R8 period fixed during realign", int'(pmin == 10 && pmax == 10), 1);

    // strict mode
    mode = 2'd2;
    seg_start(); slip_bits(5); commas(3); fill(6);
    chk("R7 three consecutive no realign", re_cnt, 0);
    chk("R7 three consecutive not framed", int'(saw_p), 0);
    seg_start(); commas(4); fill(2); commas(1); fill(6);
    chk("R7 four consecutive realigns", re_cnt, 1);
    chk("R7 four consecutive framed", int'(saw_p), 1);
    chk("R8 period fixed in strict mode", int'(pmin == 10 && pmax == 10), 1);
    mode = 2'd3;
    seg_start(); slip_bits(2); commas(4); fill(2); commas(1); fill(6);
    chk("R7 mode 3 four consecutive realigns", re_cnt, 1);
    chk("R7 mode 3 framed", int'(saw_p), 1);

    // freeze
    mode = 2'd0; frame_en = 1'b0;
    seg_start(); slip_bits(4); commas(4); fill(6); commas(1); fill(6);
    chk("R9 frozen no realign", re_cnt, 0);
    chk("R9 frozen boundary kept", int'(saw_p), 0);
    chk("R9 frozen period unchanged", int'(pmin == 10 && pmax == 10), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule